// File: doc/BRIEF.md
# Receive FIFO with Line Status

This block is the receive-side store of a UART. A deserializer pushes each received character along with three error tags: break, framing and parity. The host drains the characters through a small register bus. Each stored entry keeps its own tags. The line status byte shows only the tags of the entry now at the head, so software reads status first and then the character the status describes.

The host selects one of two registers on each read:

- **Holding register.** Returns the head character and removes it from the buffer.
- **Status byte.** Reports occupancy, a summary error flag, an overrun flag, the head entry's tags, and the two transmitter-empty inputs, which are copied through unchanged.

Reading the status byte never disturbs the buffer contents.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the buffer is empty, `fifo_empty` is 1, `fifo_full` is 0, and with `thr_empty` and `tx_idle` both high the status byte reads 0x60.
- R2: Entries leave in arrival order. The buffer holds `DEPTH` (64) entries and `fifo_full` is 1 exactly when it holds 64. `rd_sel` 0 selects the holding register, whose value is the head character, and a read of it with `rd_en` high removes the head at the next rising edge. `rd_data` follows `rd_sel` and the stored state within the same cycle.
- R3: Status bits 4, 3 and 2 are the break, framing and parity tags of the head entry, and all three read 0 when the buffer is empty.
- R4: A status read (`rd_sel` 1) never removes or reorders an entry.
- R5: Status bit 7 is 1 while any stored entry carries at least one tag, and 0 once none does. This holds when a tagged entry is pushed and popped in the same cycle.
- R6: Status bit 0 is 1 whenever the buffer holds at least one character.
- R7: An entry pushed with its break tag set is stored with data 0x00, whatever byte came with it.
- R8: A push while the buffer is full, with no holding-register pop in the same cycle, is discarded and sets the overrun flag, status bit 1. A status read returns the current flag and clears it at the next edge. A new overrun in the same cycle keeps the flag set.
- R9: Status bit 5 equals `thr_empty` and status bit 6 equals `tx_idle` in the same cycle.
- R10: A holding-register read while the buffer is empty returns 0x00 and changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push strobe from the deserializer |
| wr_data | input | 8 | Received character |
| wr_brk | input | 1 | Break tag of the pushed character |
| wr_frm | input | 1 | Framing-error tag of the pushed character |
| wr_par | input | 1 | Parity-error tag of the pushed character |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 1 | Register select: 0 holding register, 1 status byte |
| thr_empty | input | 1 | Transmit holding register empty, copied to status bit 5 |
| tx_idle | input | 1 | Transmit holding and shift registers empty, copied to status bit 6 |
| rd_data | output | 8 | Value of the selected register |
| fifo_full | output | 1 | Buffer holds `DEPTH` entries |
| fifo_empty | output | 1 | Buffer holds no entry |

## Verification
`rd_data`, `fifo_full` and `fifo_empty` are combinational views of the stored state and the current select. They are therefore due in the same cycle as the select. Pushes, pops and overrun set/clear take effect at the next rising edge and first show in the following cycle.

The bench drives every input at the falling edge and compares all outputs against a queue-based model one nanosecond later. It advances the model only after the rising edge, so each comparison sees exactly one edge's worth of change.

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_brk,
  input  logic          wr_frm,
  input  logic          wr_par,
  input  logic          rd_en,
  input  logic          rd_sel,
  input  logic          thr_empty,
  input  logic          tx_idle,
  output logic [DW-1:0] rd_data,
  output logic          fifo_full,
  output logic          fifo_empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [DW-1:0] mem_d [DEPTH];
  logic [2:0]    mem_t [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, err_cnt;
  logic          ovr;

  logic [2:0]    in_tag, head_t;
  logic [DW-1:0] head_d;
  logic          push, pop, push_err, pop_err, ovr_evt, st_rd;
  logic [7:0]    status;

  assign fifo_empty = (count == '0);
  assign fifo_full  = (count == FULLV);
  assign in_tag     = {wr_brk, wr_frm, wr_par};
  assign head_t     = mem_t[rptr];
  assign head_d     = mem_d[rptr];

  assign pop      = rd_en & ~rd_sel & ~fifo_empty;
  assign push     = wr_en & (~fifo_full | pop);
  assign ovr_evt  = wr_en & ~push;
  assign st_rd    = rd_en & rd_sel;
  assign push_err = push & (|in_tag);
  assign pop_err  = pop & (|head_t);

  always_ff @(posedge clk) begin
    if (push) begin
      mem_d[wptr] <= wr_brk ? '0 : wr_data;
      mem_t[wptr] <= in_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (push && !pop) count <= count + 1'b1;
    else if (pop && !push) count <= count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_cnt <= '0;
    else if (push_err && !pop_err) err_cnt <= err_cnt + 1'b1;
    else if (pop_err && !push_err) err_cnt <= err_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr <= 1'b0;
    else if (ovr_evt) ovr <= 1'b1;
    else if (st_rd) ovr <= 1'b0;
  end

  assign status = {err_cnt != '0, tx_idle, thr_empty,
                   fifo_empty ? 3'b000 : head_t, ovr, ~fifo_empty};

  always_comb begin
    if (rd_sel) rd_data = DW'(status);
    else if (fifo_empty) rd_data = '0;
    else rd_data = head_d;
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLV);

  // R5
  err_within_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= count);

  // R4
  status_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && !wr_en) |=> ($stable(count) && $stable(rptr)));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && fifo_empty && !wr_en) |=> (fifo_empty && $stable(rptr)));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full && !(rd_en && !rd_sel)) |=> (ovr && fifo_full && $stable(wptr)));

  // R7
  break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_brk && fifo_empty) |=> (head_d == '0));

endmodule

// File: tb/tb_rx_status_fifo.sv
`timescale 1ns/1ps
module tb_rx_status_fifo;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_brk = 0, wr_frm = 0, wr_par = 0;
  logic [7:0] wr_data = 0;
  logic rd_en = 0, rd_sel = 0, thr_empty = 1, tx_idle = 1;
  logic [7:0] rd_data;
  logic fifo_full, fifo_empty;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [10:0] q[$];
  bit m_ovr = 0;

  always #5 clk = ~clk;

  rx_status_fifo dut (.*);

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit any_err();
    foreach (q[i]) if (q[i][10:8] != 3'b000) return 1;
    return 0;
  endfunction

  task automatic compare();
    bit emp = (q.size() == 0);
    logic [2:0] ht = emp ? 3'b000 : q[0][10:8];
    check("R2 full flag", fifo_full, q.size() == DEPTH);
    check(rd_sel ? "R4 empty flag" : "R2 empty flag", fifo_empty, emp);
    if (rd_sel) begin
      check("R5 error summary bit7", rd_data[7], any_err());
      check("R9 tx idle bit6", rd_data[6], tx_idle);
      check("R9 thr empty bit5", rd_data[5], thr_empty);
      check("R3 head tags bits4:2", rd_data[4:2], ht);
      check("R8 overrun bit1", rd_data[1], m_ovr);
      check("R6 data ready bit0", rd_data[0], !emp);
    end else if (emp) begin
      check("R10 empty holding read", rd_data, 0);
    end else if (q[0][10]) begin
      check("R7 break data", rd_data, q[0][7:0]);
    end else begin
      check("R2 holding data", rd_data, q[0][7:0]);
    end
  endtask

  task automatic cyc(bit we, logic [7:0] wd, bit b, bit f, bit p,
                     bit re, bit sel, bit te = 1, bit ti = 1);
    bit pop, full;
    @(negedge clk);
    wr_en = we; wr_data = wd; wr_brk = b; wr_frm = f; wr_par = p;
    rd_en = re; rd_sel = sel; thr_empty = te; tx_idle = ti;
    #1 compare();
    @(posedge clk);
    full = (q.size() == DEPTH);
    pop = re && !sel && q.size() > 0;
    if (re && sel) m_ovr = 0;
    if (pop) void'(q.pop_front());
    if (we) begin
      if (!full || pop) q.push_back({b, f, p, (b ? 8'h00 : wd)});
      else m_ovr = 1;
    end
  endtask

  task automatic push(logic [7:0] d, bit b = 0, bit f = 0, bit p = 0);
    cyc(1, d, b, f, p, 0, 1);
  endtask
  task automatic rd_hold(); cyc(0, 0, 0, 0, 0, 1, 0); endtask
  task automatic rd_stat(); cyc(0, 0, 0, 0, 0, 1, 1); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rd_sel = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    check("R1 reset status", rd_data, 8'h60);
    check("R1 reset empty", fifo_empty, 1);
    check("R1 reset full", fifo_full, 0);

    // R2 R3 R5 R7: mixed tags, status before each pop
    push(8'h41); push(8'h55, 1); push(8'h33, 0, 0, 1); push(8'h7e, 0, 1, 0);
    for (int i = 0; i < 4; i++) begin rd_stat(); rd_hold(); end
    rd_stat(); rd_hold(); rd_hold(); rd_stat();

    // R5: tagged push and tagged pop together
    push(8'h10, 0, 0, 1);
    cyc(1, 8'h20, 0, 1, 0, 1, 0);
    rd_stat(); rd_hold(); rd_stat();

    // R2 R8: fill, overrun, clear by status read
    for (int i = 0; i < DEPTH; i++) push(8'(i + 1), 0, (i % 8) == 3, 0);
    push(8'hee); push(8'hef, 1);
    rd_stat(); rd_stat();
    // R8 set wins over clear
    cyc(1, 8'hab, 0, 0, 0, 1, 1);
    rd_stat(); rd_stat();
    // R2 push and pop at full are both accepted
    cyc(1, 8'hcd, 0, 0, 1, 1, 0);
    rd_stat();
    // R9 transmitter flags
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0);
    // R4 status reads do not drain
    for (int i = 0; i < 5; i++) rd_stat();
    for (int i = 0; i < DEPTH + 4; i++) rd_hold();
    // R10 empty reads
    rd_stat(); rd_hold(); rd_hold(); rd_stat();

    // random traffic in phases of varying push pressure
    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 700; i++) begin
        int pw = (ph % 2 == 0) ? 80 : 30;
        bit we = ($urandom_range(99) < pw);
        bit re = ($urandom_range(99) < 55);
        bit sel = $urandom_range(2) == 0;
        bit b = ($urandom_range(9) == 0);
        cyc(we, 8'($urandom), b, $urandom_range(6) == 0, $urandom_range(6) == 0,
            re, sel, $urandom_range(1), $urandom_range(1));
      end
    end
    while (q.size() > 0) rd_hold();
    rd_stat();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule